// File: doc/BRIEF.md
# Fault Line Indicator with Pulse Stretch

This block merges several internal fault flags into one active-low error line shared by other devices. The line is open-drain style. The block only ever pulls it low. Otherwise it lets the line float to an external pull-up, so any device on the wire can also drag it low.

A fault that lasts only one clock still yields a low period long enough for a slow host to notice. A countdown driven by a slow prescaler tick holds the line low after the last fault clears. The countdown restarts whenever a fault is seen again.

A mode input selects how the line is driven:
- **Steady mode:** the line is held low for the whole active period.
- **Pulsed mode:** the line repeats a slow low/high pattern counted in prescaler ticks.

The block samples the line level back through a two-stage synchronizer. It flags a low level that it is not causing itself as an externally forced fault.

Top module: `fault_line_ctrl`

## Requirements
- R1: While reset is held and right after it, `line_pull` is 0, `line_level` is 1 and `ext_fault` is 0.
- R2: When any bit of `fault_in` is 1 at a rising clock edge, `line_pull` is 1 from that edge on, in steady mode (`mode_sel` = 0).
- R3: Once `fault_in` is all zeros, steady mode keeps `line_pull` at 1 until STRETCH_TICKS clocks with `tick` = 1 have been sampled. It drops to 0 right after the edge that samples the last of those ticks. Clocks with `tick` = 0 do not shorten the hold.
- R4: A fault seen during the hold, including one in the same cycle as a tick, restarts the full STRETCH_TICKS hold.
- R5: In pulsed mode (`mode_sel` = 1), while active, `line_pull` is 1 for the first PWM_LOW ticks and 0 for the rest of each PWM_PERIOD-tick cycle, repeating. The pattern begins at its low phase on the edge where the block becomes active.
- R6: `line_level` equals `line_in` delayed by two clock edges.
- R7: `ext_fault` is 1 exactly when `line_level` is 0 and the block was not pulling the line two edges earlier. A low level caused only by the block's own pull never sets it.
- R8: With `fault_in` all zeros and no hold pending, `tick` pulses leave `line_pull` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescaler tick, one clock wide, that times the hold and the pulse pattern |
| fault_in | input | NUM_SRC | Fault flags, one per source; any bit set is a fault |
| mode_sel | input | 1 | 0 = steady low while active, 1 = pulsed pattern while active |
| line_in | input | 1 | Raw level read back from the shared error line |
| line_pull | output | 1 | 1 = drive the line low; 0 = release it to the pull-up |
| line_level | output | 1 | Synchronized line level |
| ext_fault | output | 1 | The line is low while this block is not pulling it |

## Verification
A hold counter that is loaded with the wrong value, or that counts clocks instead of ticks, shows up as `line_pull` releasing on the wrong sampled edge after the last fault. The bench catches this within STRETCH_TICKS ticks of the fault clearing. A pulse phase that does not restart at activation, or wraps at the wrong count, moves the low slots of the pattern within the first PWM_PERIOD ticks. A misaligned history of the block's own pull shows as a one-cycle `ext_fault` glitch two edges after the line is pulled or released.

// File: rtl/fault_line_pkg.sv
package fault_line_pkg;

    typedef enum logic {
        SIG_STEADY = 1'b0,
        SIG_PULSED = 1'b1
    } sig_mode_e;

    typedef struct packed {
        logic active;   // fault present or hold pending
        logic pull;     // line driven low this cycle
    } line_state_t;

    function automatic int unsigned cnt_width(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/fault_hold.sv
module fault_hold #(
    parameter int unsigned NUM_SRC       = 3,
    parameter int unsigned STRETCH_TICKS = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic [NUM_SRC-1:0] fault_in,
    output logic               active
);
    import fault_line_pkg::*;

    localparam int unsigned CW = cnt_width(STRETCH_TICKS);
    localparam logic [CW-1:0] LOAD = CW'(STRETCH_TICKS);

    logic [CW-1:0] hold_cnt;
    logic          any_fault;

    assign any_fault = |fault_in;

    always_ff @(posedge clk) begin
        if (rst)
            hold_cnt <= '0;
        else if (any_fault)
            hold_cnt <= LOAD;
        else if (tick && hold_cnt != '0)
            hold_cnt <= hold_cnt - 1'b1;
    end

    assign active = (hold_cnt != '0);

    a_r2_fault_loads_hold: assert property (@(posedge clk) disable iff (rst)
        any_fault |=> (hold_cnt == LOAD));
    a_r3_hold_waits_for_tick: assert property (@(posedge clk) disable iff (rst)
        (!any_fault && !tick) |=> $stable(hold_cnt));
    a_r3_hold_steps_once: assert property (@(posedge clk) disable iff (rst)
        (!any_fault && tick && hold_cnt != '0) |=> (hold_cnt == $past(hold_cnt) - 1'b1));
    a_r8_idle_stays_idle: assert property (@(posedge clk) disable iff (rst)
        (!any_fault && hold_cnt == '0) |=> (hold_cnt == '0));

endmodule

// File: rtl/fault_pulse_gen.sv
module fault_pulse_gen #(
    parameter int unsigned PWM_PERIOD = 32,
    parameter int unsigned PWM_LOW    = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic active,
    output logic pulse_low
);
    import fault_line_pkg::*;

    localparam int unsigned PW = cnt_width(PWM_PERIOD - 1);
    localparam logic [PW-1:0] LAST = PW'(PWM_PERIOD - 1);
    localparam logic [PW-1:0] LOWN = PW'(PWM_LOW);

    logic [PW-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst || !active)
            phase <= '0;
        else if (tick)
            phase <= (phase == LAST) ? '0 : phase + 1'b1;
    end

    assign pulse_low = (phase < LOWN);

    a_r5_phase_in_range: assert property (@(posedge clk) disable iff (rst)
        phase <= LAST);
    a_r5_idle_restarts_phase: assert property (@(posedge clk) disable iff (rst)
        !active |=> (phase == '0));

endmodule

// File: rtl/line_sampler.sv
module line_sampler (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    input  logic own_pull,
    output logic line_level,
    output logic ext_fault
);
    logic [1:0] sync_q;
    logic [1:0] pull_q;
    logic [1:0] primed;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 2'b11;
            pull_q <= 2'b00;
            primed <= 2'b00;
        end else begin
            sync_q <= {sync_q[0], line_in};
            pull_q <= {pull_q[0], own_pull};
            primed <= {primed[0], 1'b1};
        end
    end

    assign line_level = sync_q[1];
    assign ext_fault  = ~sync_q[1] & ~pull_q[1];

    a_r6_two_edge_delay: assert property (@(posedge clk) disable iff (rst)
        primed[1] |-> (line_level == $past(line_in, 2)));
    a_r7_not_own_pull: assert property (@(posedge clk) disable iff (rst)
        (primed[1] && ext_fault) |-> !$past(own_pull, 2));

endmodule

// File: rtl/fault_line_ctrl.sv
module fault_line_ctrl #(
    parameter int unsigned NUM_SRC       = 3,
    parameter int unsigned STRETCH_TICKS = 10,
    parameter int unsigned PWM_PERIOD    = 32,
    parameter int unsigned PWM_LOW       = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic [NUM_SRC-1:0] fault_in,
    input  logic               mode_sel,
    input  logic               line_in,
    output logic               line_pull,
    output logic               line_level,
    output logic               ext_fault
);
    import fault_line_pkg::*;

    line_state_t st;
    sig_mode_e   mode;
    logic        pulse_low;

    assign mode = sig_mode_e'(mode_sel);

    fault_hold #(.NUM_SRC(NUM_SRC), .STRETCH_TICKS(STRETCH_TICKS)) u_hold (
        .clk(clk), .rst(rst), .tick(tick), .fault_in(fault_in), .active(st.active)
    );

    fault_pulse_gen #(.PWM_PERIOD(PWM_PERIOD), .PWM_LOW(PWM_LOW)) u_pulse (
        .clk(clk), .rst(rst), .tick(tick), .active(st.active), .pulse_low(pulse_low)
    );

    always_comb begin
        if (mode == SIG_PULSED)
            st.pull = st.active & pulse_low;
        else
            st.pull = st.active;
    end

    line_sampler u_samp (
        .clk(clk), .rst(rst), .line_in(line_in), .own_pull(st.pull),
        .line_level(line_level), .ext_fault(ext_fault)
    );

    assign line_pull = st.pull;

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> (!line_pull && line_level && !ext_fault));
    a_r2_steady_pulls_after_fault: assert property (@(posedge clk) disable iff (rst)
        ((|fault_in) && mode_sel == 1'b0) |=> (mode_sel == 1'b1 || line_pull));

endmodule

// File: tb/tb_fault_line_ctrl.sv
module tb_fault_line_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [2:0] fault_in = 3'b000;
    logic       mode_sel = 1'b0;
    logic       ext_pull = 1'b0;
    logic       line_in;
    logic       line_pull, line_level, ext_fault;
    int         n_chk = 0;
    int         n_fail = 0;

    always #2 clk = ~clk;

    assign line_in = ~(line_pull | ext_pull);

    fault_line_ctrl #(.NUM_SRC(3), .STRETCH_TICKS(3), .PWM_PERIOD(4), .PWM_LOW(1)) dut (
        .clk(clk), .rst(rst), .tick(tick), .fault_in(fault_in), .mode_sel(mode_sel),
        .line_in(line_in), .line_pull(line_pull), .line_level(line_level), .ext_fault(ext_fault)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // {fault[2:0], tick, expected line_pull}; steady mode, hold = 3 ticks
    localparam logic [4:0] VEC [15] = '{
        5'b000_0_0,  // idle R8
        5'b000_1_0,  // tick alone, R8
        5'b001_0_1,  // R2 source 0
        5'b000_1_1,  // hold 2
        5'b000_0_1,  // no tick, R3
        5'b000_1_1,  // hold 1
        5'b100_0_1,  // R4 reload, source 2
        5'b000_1_1,
        5'b000_1_1,
        5'b000_1_0,  // R3 release
        5'b000_1_0,
        5'b010_1_1,  // R4 fault with tick, source 1
        5'b000_1_1,
        5'b000_1_1,
        5'b000_1_0   // R3
    };

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        fault_in = 3'b111;
        @(negedge clk);
        step(); step();
        check("R1", line_pull, 1'b0);
        check("R1", line_level, 1'b1);
        check("R1", ext_fault, 1'b0);
        fault_in = 3'b000;
        rst = 1'b0;
        step();
        check("R1", line_pull, 1'b0);

        for (int i = 0; i < 15; i++) begin
            fault_in = VEC[i][4:2];
            tick     = VEC[i][1];
            step();
            check(VEC[i][0] ? "R2/R4" : "R3/R8", line_pull, VEC[i][0]);
            check("R7", ext_fault, 1'b0);
        end
        tick = 1'b0; fault_in = 3'b000;
        step(); step();

        // pulsed mode: pattern 1,0,0,0 per 4 ticks
        mode_sel = 1'b1;
        fault_in = 3'b001;
        tick = 1'b1;
        for (int i = 0; i < 8; i++) begin
            step();
            check("R5", line_pull, (i % 4) == 0);
            check("R7", ext_fault, 1'b0);
        end
        fault_in = 3'b000;
        tick = 1'b0;
        mode_sel = 1'b0;
        step();
        tick = 1'b1;
        step(); step(); step(); step();
        tick = 1'b0;
        check("R3", line_pull, 1'b0);
        step(); step();

        // external pull: two-edge sampling delay
        ext_pull = 1'b1;
        step();
        check("R6", line_level, 1'b1);
        check("R7", ext_fault, 1'b0);
        step();
        check("R6", line_level, 1'b0);
        check("R7", ext_fault, 1'b1);
        ext_pull = 1'b0;
        step();
        check("R6", line_level, 1'b0);
        step();
        check("R6", line_level, 1'b1);
        check("R7", ext_fault, 1'b0);

        // own pull only: level low, no ext flag
        fault_in = 3'b100;
        step();
        fault_in = 3'b000;
        check("R2", line_pull, 1'b1);
        step(); step();
        check("R6", line_level, 1'b0);
        check("R7", ext_fault, 1'b0);
        tick = 1'b1;
        for (int i = 0; i < 6; i++) begin
            step();
            check("R7", ext_fault, 1'b0);
        end
        tick = 1'b0;
        check("R6", line_level, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule